// File: doc/BRIEF.md
# Serial Display Byte Transmitter

This block turns host bytes into traffic on a four-wire serial display link. The four lines are an active-low select, a line that marks a byte as command or data, a serial clock and a serial data line. The host starts a transaction with a one-cycle `start_i` pulse. With it, the host says whether the transaction is a single command byte or a data burst, and for a burst it gives the byte count. The host then hands over the bytes one at a time through a valid/ready handshake.

A whole burst goes out under a single select assertion. Every bit is presented while the clock is low and is sampled by the display on the next rising clock edge. The length of each clock phase is fixed by the `HALF_CYC` parameter, counted in system clock cycles. The block stays busy until all four lines are back at their high idle level. If the host is slow to supply the next byte, the link pauses with the clock held high and the select still asserted.

Top module: `serial_disp_tx`

## Requirements
- R1: After a synchronous active-low reset, `cs_n_o`, `dc_o`, `sclk_o` and `sdat_o` are all 1, and `busy_o` and `byte_ready_o` are 0.
- R2: `cs_n_o` goes low once per accepted transaction and stays low until that transaction's last bit has been clocked. Every rising edge of `sclk_o` happens while `cs_n_o` is low.
- R3: `dc_o` is 0 for a command transaction (`is_cmd_i`=1) and 1 for a data transaction. It does not change while the transaction runs.
- R4: Each byte goes out most significant bit first, one bit per `sclk_o` period. `sdat_o` does not change on the cycle in which `sclk_o` rises.
- R5: Within a byte, every low phase and every high phase of `sclk_o` lasts exactly `HALF_CYC` system clock cycles.
- R6: A command transaction carries exactly one byte, whatever `byte_cnt_i` holds. A data transaction carries `byte_cnt_i` bytes, and a count of 0 is treated as 1.
- R7: A byte is taken on a cycle where `byte_valid_i` and `byte_ready_o` are both 1. `byte_ready_o` is 1 only between bytes, never while a byte is partly shifted.
- R8: While the block waits for a data byte after the first byte of a burst, `sclk_o` stays high and `cs_n_o` stays low. The burst then resumes and does not end early.
- R9: `busy_o` rises the cycle after a start is accepted. It falls in the same cycle that all four lines return to 1 after the last bit's high phase.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored: it changes no line of the running transaction and opens no later transaction.
- R11: When `cs_n_o` falls, `sclk_o` is 0 and `sdat_o` is 1, before the first bit is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to open a transaction |
| is_cmd_i | input | 1 | 1: single command byte, 0: data burst (sampled with start_i) |
| byte_cnt_i | input | CNT_W | Burst length for data transactions (sampled with start_i) |
| byte_data_i | input | BYTE_W | Byte offered by the host |
| byte_valid_i | input | 1 | Host byte is valid |
| byte_ready_o | output | 1 | Block will take a byte this cycle |
| busy_o | output | 1 | Transaction in progress |
| cs_n_o | output | 1 | Active-low display select |
| dc_o | output | 1 | 0 command, 1 data |
| sclk_o | output | 1 | Serial clock |
| sdat_o | output | 1 | Serial data |

## Verification
Several properties are checked on every cycle:
- `sdat_o` is steady when `sclk_o` rises.
- Select is low whenever a bit is clocked.
- The idle lines are high whenever the block is not busy.
- `dc_o` holds for the whole transaction.
- Ready is confined to the waiting state.
- The phase counter and the burst counter stay within their bounds.

Other behaviour shows up only in the bench's scenarios:
- Whether the right bytes arrive in the right bit order.
- The burst length, including the zero-count and command-ignores-count cases.
- The exact phase lengths.
- The pause behaviour under host stalls.
- That a start pulse during a burst leaves no trace.

The bench covers these with a sweep over all 256 command bytes and with data bursts up to 255 bytes.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_LO   = 2'd2,
      ST_HI   = 2'd3
   } sdt_state_e;
endpackage

// File: rtl/sdt_phase_timer.sv
// Counts the length of one serial clock phase.
module sdt_phase_timer #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   generate
      if (HALF_CYC < 1) begin : g_bad
         $error("sdt_phase_timer: HALF_CYC must be at least 1");
      end else if (HALF_CYC == 1) begin : g_one
         // every cycle ends a phase; no counter needed
         assign done_o = run_i;
      end else begin : g_cnt
         localparam int CW = $clog2(HALF_CYC);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)                cnt_q <= '0;
            else if (!run_i || done_o) cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end

         assign done_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

         a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(HALF_CYC - 1));
         a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !run_i |=> cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/sdt_shifter.sv
// Holds the bits of the current byte not yet presented, plus a bit index.
module sdt_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-2:0] rest_i,
   input  logic              shift_i,
   output logic              next_bit_o,
   output logic              last_o
);
   localparam int IW = $clog2(BYTE_W);

   generate
      if (BYTE_W < 2) begin : g_bad
         $error("sdt_shifter: BYTE_W must be at least 2");
      end
   endgenerate

   logic [BYTE_W-2:0] sh_q;
   logic [IW-1:0]     idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= rest_i;
         idx_q <= IW'(BYTE_W - 1);
      end else if (shift_i) begin
         sh_q  <= sh_q << 1;
         idx_q <= idx_q - 1'b1;
      end
   end

   assign next_bit_o = sh_q[BYTE_W-2];
   assign last_o     = (idx_q == '0);

   a_r4_no_shift_past_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |-> idx_q != '0);
endmodule

// File: rtl/sdt_burst_count.sv
// Bytes still owed in the running transaction.
module sdt_burst_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             is_cmd_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             dec_i,
   output logic             last_o
);
   generate
      if (CNT_W < 1) begin : g_bad
         $error("sdt_burst_count: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rem_q <= '0;
      else if (load_i)
         rem_q <= (is_cmd_i || cnt_i == '0) ? CNT_W'(1) : cnt_i;
      else if (dec_i)
         rem_q <= rem_q - 1'b1;
   end

   assign last_o = (rem_q == CNT_W'(1));

   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i |-> rem_q > CNT_W'(1));
endmodule

// File: rtl/serial_disp_tx.sv
module serial_disp_tx
   import sdt_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int CNT_W    = 8,
   parameter int HALF_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              is_cmd_i,
   input  logic [CNT_W-1:0]  byte_cnt_i,
   input  logic [BYTE_W-1:0] byte_data_i,
   input  logic              byte_valid_i,
   output logic              byte_ready_o,
   output logic              busy_o,
   output logic              cs_n_o,
   output logic              dc_o,
   output logic              sclk_o,
   output logic              sdat_o
);
   sdt_state_e state_q;
   logic cs_q, dc_q, sclk_q, sdat_q;

   logic t_run, t_done;
   logic ld_cnt, ld_sh, do_shift, do_dec;
   logic bit_next, bit_last, byte_last;

   // -------------------------------------------------------------------------
   // Strobes derived from the state
   // -------------------------------------------------------------------------
   assign t_run    = (state_q == ST_LO) || (state_q == ST_HI);
   assign ld_cnt   = (state_q == ST_IDLE) && start_i;
   assign ld_sh    = (state_q == ST_WAIT) && byte_valid_i;
   assign do_shift = (state_q == ST_HI) && t_done && !bit_last;
   assign do_dec   = (state_q == ST_HI) && t_done && bit_last && !byte_last;

   // -------------------------------------------------------------------------
   // Sub-blocks
   // -------------------------------------------------------------------------
   sdt_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(t_run), .done_o(t_done)
   );

   sdt_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(ld_sh),
      .rest_i(byte_data_i[BYTE_W-2:0]), .shift_i(do_shift),
      .next_bit_o(bit_next), .last_o(bit_last)
   );

   sdt_burst_count #(.CNT_W(CNT_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .load_i(ld_cnt), .is_cmd_i(is_cmd_i),
      .cnt_i(byte_cnt_i), .dec_i(do_dec), .last_o(byte_last)
   );

   // -------------------------------------------------------------------------
   // Sequencer and line registers
   // -------------------------------------------------------------------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cs_q    <= 1'b1;
         dc_q    <= 1'b1;
         sclk_q  <= 1'b1;
         sdat_q  <= 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_WAIT;
               cs_q    <= 1'b0;
               dc_q    <= !is_cmd_i;
               sclk_q  <= 1'b0;
               sdat_q  <= 1'b1;
            end
            ST_WAIT: if (byte_valid_i) begin
               state_q <= ST_LO;
               sclk_q  <= 1'b0;
               sdat_q  <= byte_data_i[BYTE_W-1];
            end
            ST_LO: if (t_done) begin
               state_q <= ST_HI;
               sclk_q  <= 1'b1;
            end
            ST_HI: if (t_done) begin
               if (!bit_last) begin
                  state_q <= ST_LO;
                  sclk_q  <= 1'b0;
                  sdat_q  <= bit_next;
               end else if (!byte_last) begin
                  state_q <= ST_WAIT;   // clock parked high
               end else begin
                  state_q <= ST_IDLE;
                  cs_q    <= 1'b1;
                  dc_q    <= 1'b1;
                  sclk_q  <= 1'b1;
                  sdat_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign byte_ready_o = (state_q == ST_WAIT);
   assign busy_o       = (state_q != ST_IDLE);
   assign cs_n_o       = cs_q;
   assign dc_o         = dc_q;
   assign sclk_o       = sclk_q;
   assign sdat_o       = sdat_q;

   // -------------------------------------------------------------------------
   // Assertions
   // -------------------------------------------------------------------------
   a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && dc_o && sclk_o && sdat_o));
   a_r2_cs_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> !cs_n_o);
   a_r3_dc_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(dc_o));
   a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> $stable(sdat_o));
   a_r7_ready_between: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready_o |-> (busy_o && !cs_n_o));
   a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && state_q != ST_HI) |=> busy_o);
endmodule

// File: tb/tb_serial_disp_tx.sv
`timescale 1ns/1ps
module tb_serial_disp_tx;
   localparam int BYTE_W   = 8;
   localparam int CNT_W    = 8;
   localparam int HALF_CYC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, is_cmd_i = 1'b0, byte_valid_i = 1'b0;
   logic [CNT_W-1:0]  byte_cnt_i = '0;
   logic [BYTE_W-1:0] byte_data_i = '0;
   logic byte_ready_o, busy_o, cs_n_o, dc_o, sclk_o, sdat_o;

   always #2.5 clk = ~clk;

   serial_disp_tx #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .HALF_CYC(HALF_CYC)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_cmd_i(is_cmd_i),
      .byte_cnt_i(byte_cnt_i), .byte_data_i(byte_data_i),
      .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
      .busy_o(busy_o), .cs_n_o(cs_n_o), .dc_o(dc_o),
      .sclk_o(sclk_o), .sdat_o(sdat_o)
   );

   int checks = 0, fails = 0, cyc = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         check(0, "watchdog", cyc, 150000);
         finish_run();
      end
   end

   // ---------------- line monitor (samples on the falling edge) ----------------
   logic [7:0] rx_q [0:1023];
   int rx_n = 0, txn_count = 0, bits = 0, txn_bytes = 0;
   int hi_len = 0, lo_len = 0;
   bit lo_chk = 0, txn_dc = 0;
   bit prev_cs = 1, prev_sclk = 1;
   logic [7:0] shbuf = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs && !cs_n_o) begin
            txn_count++;
            txn_dc = dc_o;
            txn_bytes = 0;
            check(sclk_o == 0 && sdat_o == 1, "R11 preset", {sclk_o, sdat_o}, 1);
         end
         if (!cs_n_o && !prev_cs)
            if (dc_o != txn_dc) check(0, "R3 dc moved", dc_o, txn_dc);
         if (!prev_cs && cs_n_o)
            check(dc_o && sclk_o && sdat_o && !busy_o && bits == 0,
                  "R9 idle lines", {busy_o, dc_o, sclk_o, sdat_o}, 7);
         if (!prev_sclk && sclk_o) begin
            if (cs_n_o) check(0, "R2 edge without select", cs_n_o, 0);
            if (lo_chk) check(lo_len == HALF_CYC, "R5 low phase", lo_len, HALF_CYC);
            shbuf = {shbuf[6:0], sdat_o};
            bits++;
            hi_len = 1;
            if (bits == 8) begin
               rx_q[rx_n] = shbuf;
               rx_n++;
               txn_bytes++;
               bits = 0;
            end
         end else if (prev_sclk && !sclk_o) begin
            if (bits != 0) check(hi_len == HALF_CYC, "R5 high phase", hi_len, HALF_CYC);
            lo_chk = (bits != 0);
            lo_len = 1;
         end else if (sclk_o) hi_len++;
         else lo_len++;
         if (byte_ready_o && bits != 0) check(0, "R7 ready mid-byte", bits, 0);
         if (byte_ready_o && txn_bytes > 0)
            if (!(sclk_o && !cs_n_o)) check(0, "R8 stall lines", {sclk_o, cs_n_o}, 2);
      end
      prev_cs = cs_n_o;
      prev_sclk = sclk_o;
   end

   // ---------------- host side ----------------
   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed + i * 13 + (i >> 2)) & 255);
   endfunction

   task automatic send_byte(input logic [7:0] v);
      @(posedge clk); #1;
      byte_valid_i = 1'b1;
      byte_data_i  = v;
      forever begin
         @(negedge clk);
         if (byte_ready_o) break;
      end
      @(posedge clk); #1;
      byte_valid_i = 1'b0;
      byte_data_i  = ~v;   // must not be picked up
   endtask

   task automatic run_txn(input bit cmd, input int cnt, input int seed,
                          input bit stall, input bit glitch);
      int n, rx_base, t_base;
      n = cmd ? 1 : (cnt == 0 ? 1 : cnt);
      while (busy_o) @(negedge clk);
      rx_base = rx_n;
      t_base  = txn_count;
      @(posedge clk); #1;
      start_i = 1'b1; is_cmd_i = cmd; byte_cnt_i = CNT_W'(cnt);
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      check(busy_o == 1, "R9 busy after start", busy_o, 1);
      for (int i = 0; i < n; i++) begin
         if (stall && (i % 2 == 1))
            repeat ((i % 3 + 1) * 5) @(posedge clk);
         if (glitch && i == 1) begin
            @(posedge clk); #1;
            start_i = 1'b1; is_cmd_i = !cmd;
            @(posedge clk); #1;
            start_i = 1'b0;
         end
         send_byte(pat(seed, i));
      end
      while (busy_o) @(negedge clk);
      check(cs_n_o && dc_o && sclk_o && sdat_o && !byte_ready_o, "R9 end state",
            {cs_n_o, dc_o, sclk_o, sdat_o, byte_ready_o}, 30);
      check(rx_n - rx_base == n, "R6 byte count", rx_n - rx_base, n);
      check(txn_count - t_base == 1, "R2 one select window", txn_count - t_base, 1);
      check(txn_dc == !cmd, "R3 dc level", txn_dc, !cmd);
      for (int i = 0; i < n; i++)
         if (rx_q[rx_base + i] != pat(seed, i))
            check(0, "R4 byte value", rx_q[rx_base + i], pat(seed, i));
      check(1, "R4 bytes compared", 0, 0);
      if (glitch) begin
         repeat (10) @(negedge clk);
         check(txn_count - t_base == 1 && cs_n_o && !busy_o, "R10 start ignored",
               txn_count - t_base, 1);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(cs_n_o && dc_o && sclk_o && sdat_o, "R1 reset lines",
            {cs_n_o, dc_o, sclk_o, sdat_o}, 15);
      check(!busy_o && !byte_ready_o, "R1 reset busy/ready", {busy_o, byte_ready_o}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R6 command: every byte value, count input ignored
      for (int v = 0; v < 256; v++)
         run_txn(1'b1, v % 5, v, 1'b0, 1'b0);
      // data bursts
      run_txn(1'b0, 1, 17, 1'b0, 1'b0);
      run_txn(1'b0, 3, 90, 1'b1, 1'b0);   // R8 stalls
      run_txn(1'b0, 0, 200, 1'b0, 1'b0);  // R6 zero count
      run_txn(1'b0, 112, 3, 1'b0, 1'b0);
      run_txn(1'b0, 5, 61, 1'b1, 1'b1);   // R10 start during burst
      run_txn(1'b0, 255, 128, 1'b0, 1'b0);
      run_txn(1'b1, 0, 8'hC3, 1'b0, 1'b0);

      // R1 reset in the middle of a burst
      @(posedge clk); #1;
      start_i = 1'b1; is_cmd_i = 1'b0; byte_cnt_i = 4;
      @(posedge clk); #1;
      start_i = 1'b0; byte_valid_i = 1'b1; byte_data_i = 8'h5A;
      repeat (6) @(posedge clk); #1;
      byte_valid_i = 1'b0;
      rst_n = 1'b0;
      @(posedge clk); #1;
      @(negedge clk);
      check(cs_n_o && dc_o && sclk_o && sdat_o && !busy_o, "R1 mid reset",
            {cs_n_o, dc_o, sclk_o, sdat_o, busy_o}, 30);
      bits = 0;
      finish_run();
   end
endmodule